// File: doc/BRIEF.md
# Audio Sample FIFO Host Controller

This block sits between a host register bus and a voice codec. The host sees six byte-wide registers. Through them it writes playback samples into an output FIFO, reads captured samples from an input FIFO, and loads command bytes into a control FIFO that feeds the codec's command port. The codec side is a set of plain strobes: it pushes captured bytes, pops playback bytes and pops command bytes. Each strobe is honoured only while the matching connect bit in the control/status register is set.

Software streams samples in half-FIFO chunks. Level-derived events report when the output FIFO has drained to half or less, when the input FIFO has filled to half or more, and when the output or control FIFO is empty. Each event has an enable. The block raises a single interrupt line when an enabled event is present and the global interrupt enable is set. Writing any value to the identification register flushes all three FIFOs and clears the control/status register.

Top module: `aud_fifo_hub`

## Requirements
- R1: After reset, the control/status register (address 1) reads 0x00, the FIFO status register (address 3) reads 0x15, the interrupt register (address 2) reads 0x0E, and irq is low.
- R2: A read of address 0 returns the parameter ID_VALUE. A write of any value to address 0 empties the input, output and control FIFOs and clears the control/status register, and leaves the interrupt enables unchanged.
- R3: A host write to address 4 pushes the byte into the output FIFO. While CSR bit 0 is set, the codec pops bytes in first-in first-out order on cdc_out_data. While CSR bit 0 is clear, codec pops are ignored.
- R4: While CSR bit 0 is set, a codec push stores a byte in the input FIFO; while it is clear, codec pushes are ignored. A host read of address 4 returns the oldest byte and removes it.
- R5: A host write to address 5 pushes into the control FIFO. Codec command pops take effect, in order, only while CSR bit 2 is set.
- R6: Each data FIFO holds DATA_DEPTH (128) bytes and the control FIFO holds CTL_DEPTH (16) bytes. A push into a full FIFO is ignored. The FIFO status register reports, per FIFO, a full flag and an empty flag: bit 5 control full, bit 4 control empty, bit 3 output full, bit 2 output empty, bit 1 input full, bit 0 input empty.
- R7: A pop from an empty FIFO is ignored; the FIFO stays empty and its contents are unchanged.
- R8: Interrupt register event bits: bit 3 means the output FIFO is empty, bit 2 means the control FIFO is empty, bit 1 means the output FIFO holds 64 or fewer bytes, and bit 0 means the input FIFO holds 64 or more bytes.
- R9: In the interrupt register, bits 7..4 are writable enables, with the enable for event n at bit n+4. Bits 3..0 are read-only events, and writes to them have no effect.
- R10: CSR bit 6 reads 1 exactly when some event is set together with its enable. The irq output equals CSR bit 6 AND CSR bit 7.
- R11: Events follow the current FIFO state and clear as soon as their condition ends; no acknowledge is needed.
- R12: CSR bits 7, 3, 2 and 0 are writable and read back. Bit 6 ignores writes. Bits 5, 4 and 1 read 0. The wide_mode output follows CSR bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops input FIFO at address 4) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| cdc_in_push | input | 1 | Codec pushes a captured byte |
| cdc_in_data | input | 8 | Captured byte |
| cdc_in_ready | output | 1 | Input FIFO connected and not full |
| cdc_out_pop | input | 1 | Codec pops a playback byte |
| cdc_out_data | output | 8 | Oldest playback byte |
| cdc_out_avail | output | 1 | Output FIFO connected and not empty |
| cdc_cmd_pop | input | 1 | Codec pops a command byte |
| cdc_cmd_data | output | 8 | Oldest command byte |
| cdc_cmd_avail | output | 1 | Control FIFO connected and not empty |
| wide_mode | output | 1 | 16-bit sample width selected |
| irq | output | 1 | Interrupt request to host |

## Verification
The bench fills and drains each FIFO one byte past its capacity, checking the event and status bits at every step. This catches an off-by-one at the 64-entry thresholds, which would flip the half-level bit one byte early or late, and a full FIFO that overwrote the oldest byte, which would show up as a wrong byte when the FIFO is drained. It strobes pops and pushes while the connect bits are clear, which exposes a design that leaks samples or commands to the codec. It also checks that a write to the identification register flushes the FIFOs but keeps the enables, so a soft reset that wiped the enables, or that left stale data behind, would be caught.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;

    typedef enum logic [2:0] {
        SEL_ID     = 3'd0,
        SEL_CSR    = 3'd1,
        SEL_IRQ    = 3'd2,
        SEL_STATUS = 3'd3,
        SEL_DATA   = 3'd4,
        SEL_CMD    = 3'd5
    } reg_sel_e;

    // control/status bit positions
    localparam int CSR_IE   = 7;
    localparam int CSR_PEND = 6;
    localparam int CSR_WIDE = 3;
    localparam int CSR_CMD  = 2;
    localparam int CSR_DATA = 0;
    localparam logic [7:0] CSR_WMASK = 8'h8D;

    // event bit positions
    localparam int EV_OUT_EMPTY = 3;
    localparam int EV_CTL_EMPTY = 2;
    localparam int EV_OUT_HALF  = 1;
    localparam int EV_IN_HALF   = 0;

    typedef struct packed {
        logic full;
        logic empty;
    } fifo_flags_t;

    function automatic logic [7:0] pack_status(fifo_flags_t c, fifo_flags_t o, fifo_flags_t i);
        return {2'b00, c.full, c.empty, o.full, o.empty, i.full, i.empty};
    endfunction

endpackage

// File: rtl/aud_fifo_buf.sv
module aud_fifo_buf
    import aud_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output fifo_flags_t                  flags
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign flags.full  = (count == CW'(DEPTH));
    assign flags.empty = (count == '0);
    assign do_push = push && !flags.full;
    assign do_pop  = pop && !flags.empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/aud_irq_eval.sv
module aud_irq_eval
    import aud_fifo_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic [$clog2(DEPTH+1)-1:0] out_count,
    input  logic [$clog2(DEPTH+1)-1:0] in_count,
    input  logic                       ctl_empty,
    input  logic [3:0]                 enables,
    input  logic                       glob_en,
    output logic [3:0]                 events,
    output logic                       pending,
    output logic                       irq
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] HALF = CW'(DEPTH/2);

    always_comb begin
        events               = '0;
        events[EV_OUT_EMPTY] = (out_count == '0);
        events[EV_CTL_EMPTY] = ctl_empty;
        events[EV_OUT_HALF]  = (out_count <= HALF);
        events[EV_IN_HALF]   = (in_count >= HALF);
    end

    assign pending = |(events & enables);
    assign irq     = pending && glob_en;

endmodule

// File: rtl/aud_fifo_hub.sv
module aud_fifo_hub
    import aud_fifo_pkg::*;
#(
    parameter int         DATA_DEPTH = 128,
    parameter int         CTL_DEPTH  = 16,
    parameter logic [7:0] ID_VALUE   = 8'hA5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       cdc_in_push,
    input  logic [7:0] cdc_in_data,
    output logic       cdc_in_ready,
    input  logic       cdc_out_pop,
    output logic [7:0] cdc_out_data,
    output logic       cdc_out_avail,
    input  logic       cdc_cmd_pop,
    output logic [7:0] cdc_cmd_data,
    output logic       cdc_cmd_avail,
    output logic       wide_mode,
    output logic       irq
);
    localparam int DCW = $clog2(DATA_DEPTH+1);
    localparam int CCW = $clog2(CTL_DEPTH+1);

    logic [7:0]     csr_q;
    logic [3:0]     ir_en;
    logic [3:0]     ev;
    logic           pending;
    logic           soft_rst;
    logic [DCW-1:0] out_count, in_count;
    logic [CCW-1:0] ctl_count;
    fifo_flags_t    out_fl, in_fl, ctl_fl;
    logic [7:0]     in_head;
    logic           wr_data, wr_cmd, rd_data;

    assign soft_rst = reg_wr && (reg_addr == SEL_ID);
    assign wr_data  = reg_wr && (reg_addr == SEL_DATA);
    assign wr_cmd   = reg_wr && (reg_addr == SEL_CMD);
    assign rd_data  = reg_rd && (reg_addr == SEL_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q <= '0;
            ir_en <= '0;
        end else begin
            if (soft_rst)
                csr_q <= '0;
            else if (reg_wr && reg_addr == SEL_CSR)
                csr_q <= reg_wdata & CSR_WMASK;
            if (reg_wr && reg_addr == SEL_IRQ)
                ir_en <= reg_wdata[7:4];
        end
    end

    aud_fifo_buf #(.DEPTH(DATA_DEPTH), .W(8)) u_out_fifo (
        .clk(clk), .rst(rst), .clr(soft_rst),
        .push(wr_data), .wdata(reg_wdata),
        .pop(cdc_out_pop && csr_q[CSR_DATA]), .rdata(cdc_out_data),
        .count(out_count), .flags(out_fl)
    );

    aud_fifo_buf #(.DEPTH(DATA_DEPTH), .W(8)) u_in_fifo (
        .clk(clk), .rst(rst), .clr(soft_rst),
        .push(cdc_in_push && csr_q[CSR_DATA]), .wdata(cdc_in_data),
        .pop(rd_data), .rdata(in_head),
        .count(in_count), .flags(in_fl)
    );

    aud_fifo_buf #(.DEPTH(CTL_DEPTH), .W(8)) u_ctl_fifo (
        .clk(clk), .rst(rst), .clr(soft_rst),
        .push(wr_cmd), .wdata(reg_wdata),
        .pop(cdc_cmd_pop && csr_q[CSR_CMD]), .rdata(cdc_cmd_data),
        .count(ctl_count), .flags(ctl_fl)
    );

    aud_irq_eval #(.DEPTH(DATA_DEPTH)) u_irq_eval (
        .out_count(out_count), .in_count(in_count), .ctl_empty(ctl_fl.empty),
        .enables(ir_en), .glob_en(csr_q[CSR_IE]),
        .events(ev), .pending(pending), .irq(irq)
    );

    assign cdc_in_ready  = csr_q[CSR_DATA] && !in_fl.full;
    assign cdc_out_avail = csr_q[CSR_DATA] && !out_fl.empty;
    assign cdc_cmd_avail = csr_q[CSR_CMD] && !ctl_fl.empty;
    assign wide_mode     = csr_q[CSR_WIDE];

    always_comb begin
        case (reg_addr)
            SEL_ID:     reg_rdata = ID_VALUE;
            SEL_CSR:    reg_rdata = csr_q | (8'(pending) << CSR_PEND);
            SEL_IRQ:    reg_rdata = {ir_en, ev};
            SEL_STATUS: reg_rdata = pack_status(ctl_fl, out_fl, in_fl);
            SEL_DATA:   reg_rdata = in_head;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/aud_fifo_hub_chk.sv
module aud_fifo_hub_chk #(
    parameter int DATA_DEPTH = 128,
    parameter int CTL_DEPTH  = 16
) (
    input logic                           clk,
    input logic                           rst,
    input logic [2:0]                     reg_addr,
    input logic                           reg_wr,
    input logic                           reg_rd,
    input logic [7:0]                     csr_q,
    input logic [3:0]                     ir_en,
    input logic [3:0]                     ev,
    input logic                           irq,
    input logic [$clog2(DATA_DEPTH+1)-1:0] out_count,
    input logic [$clog2(DATA_DEPTH+1)-1:0] in_count,
    input logic [$clog2(CTL_DEPTH+1)-1:0]  ctl_count
);
    localparam int DCW = $clog2(DATA_DEPTH+1);

    // R6
    out_cap_chk: assert property (@(posedge clk) disable iff (rst)
        out_count <= DCW'(DATA_DEPTH));

    // R6
    in_full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_count == DCW'(DATA_DEPTH) && !(reg_rd && reg_addr == 3'd4) && !(reg_wr && reg_addr == 3'd0))
        |=> in_count == DCW'(DATA_DEPTH));

    // R7
    out_empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_count == '0 && !(reg_wr && reg_addr == 3'd4)) |=> out_count == '0);

    // R3
    out_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!csr_q[0] && !(reg_wr && (reg_addr == 3'd4 || reg_addr == 3'd0)))
        |=> out_count == $past(out_count));

    // R5
    ctl_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!csr_q[2] && !(reg_wr && (reg_addr == 3'd5 || reg_addr == 3'd0)))
        |=> ctl_count == $past(ctl_count));

    // R2
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd0)
        |=> (out_count == '0 && in_count == '0 && ctl_count == '0 && csr_q == 8'h00));

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (csr_q[7] && (ev & ir_en) != 4'h0));

endmodule

bind aud_fifo_hub aud_fifo_hub_chk #(.DATA_DEPTH(DATA_DEPTH), .CTL_DEPTH(CTL_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .csr_q(csr_q), .ir_en(ir_en), .ev(ev), .irq(irq),
    .out_count(out_count), .in_count(in_count), .ctl_count(ctl_count)
);

// File: tb/aud_fifo_hub_bench.sv
module aud_fifo_hub_bench;
    localparam int DEPTH = 128;
    localparam int HALF  = 64;
    localparam int CDEP  = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       cdc_in_push = 1'b0;
    logic [7:0] cdc_in_data = '0;
    logic       cdc_in_ready, cdc_out_pop = 1'b0, cdc_out_avail;
    logic [7:0] cdc_out_data, cdc_cmd_data;
    logic       cdc_cmd_pop = 1'b0, cdc_cmd_avail, wide_mode, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    aud_fifo_hub u_aud_fifo_hub (.*);

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FIFO check FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [7:0] ev_byte(int out_n, int in_n, bit ctl_e);
        return {4'h0, (out_n == 0) ? 1'b1 : 1'b0, ctl_e, (out_n <= HALF) ? 1'b1 : 1'b0,
                (in_n >= HALF) ? 1'b1 : 1'b0};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FIFO check FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        int out_n, in_n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd1, v); chk("R1 csr", v, 8'h00);
        rd(3'd3, v); chk("R1 status", v, 8'h15);
        rd(3'd2, v); chk("R1 irq reg", v, 8'h0E);
        chk("R1 irq pin", irq, 0);
        // R2 id
        rd(3'd0, v); chk("R2 id", v, 8'hA5);

        // R12 writable mask
        wr(3'd1, 8'hFF);
        rd(3'd1, v); chk("R12 csr mask", v, 8'h8D);
        chk("R12 wide", wide_mode, 1);

        // R9 / R10 enables vs events
        wr(3'd2, 8'hFF);
        rd(3'd2, v); chk("R9 ir", v, 8'hFE);
        rd(3'd1, v); chk("R10 pending", v, 8'hCD);
        chk("R10 irq on", irq, 1);
        wr(3'd2, 8'h00);
        rd(3'd2, v); chk("R9 ir clr", v, 8'h0E);
        chk("R10 irq off", irq, 0);
        wr(3'd2, 8'h80);
        chk("R10 irq outempty", irq, 1);
        wr(3'd1, 8'h0C);
        chk("R10 gated", irq, 0);
        rd(3'd1, v); chk("R10 pend w/o ie", v, 8'h4C);

        // R6/R8/R11 fill output FIFO past capacity, data path disconnected
        for (int i = 0; i < DEPTH + 2; i++) begin
            wr(3'd4, 8'((i * 7 + 3) & 8'hFF));
            out_n = (i + 1 > DEPTH) ? DEPTH : i + 1;
            rd(3'd2, v); chk("R8 out fill events", v, 8'h80 | ev_byte(out_n, 0, 1'b1));
        end
        rd(3'd3, v); chk("R6 out full", v, 8'h19);
        // R3 pops ignored while disconnected
        cdc_out_pop = 1'b1; repeat (3) @(negedge clk); cdc_out_pop = 1'b0;
        rd(3'd3, v); chk("R3 gated pop", v, 8'h19);
        chk("R3 avail off", cdc_out_avail, 0);

        // R3 drain in order, R7 pops past empty
        wr(3'd1, 8'h01);
        for (int i = 0; i < DEPTH + 2; i++) begin
            cdc_out_pop = 1'b1;
            #1;
            if (i < DEPTH) begin
                chk("R3 out order", cdc_out_data, (i * 7 + 3) & 8'hFF);
                chk("R3 avail", cdc_out_avail, 1);
            end else begin
                chk("R7 avail empty", cdc_out_avail, 0);
            end
            @(negedge clk);
            cdc_out_pop = 1'b0;
            out_n = (DEPTH - i - 1 < 0) ? 0 : DEPTH - i - 1;
            rd(3'd2, v); chk("R11 out drain events", v, 8'h80 | ev_byte(out_n, 0, 1'b1));
        end
        rd(3'd3, v); chk("R7 out empty", v, 8'h15);

        // R4 push ignored while disconnected
        wr(3'd1, 8'h00);
        cdc_in_push = 1'b1; cdc_in_data = 8'h77; @(negedge clk); cdc_in_push = 1'b0;
        rd(3'd3, v); chk("R4 gated push", v, 8'h15);

        // R4/R6/R8 fill input FIFO
        wr(3'd1, 8'h01);
        for (int i = 0; i < DEPTH + 2; i++) begin
            cdc_in_push = 1'b1; cdc_in_data = 8'((i * 13 + 5) & 8'hFF);
            @(negedge clk);
            cdc_in_push = 1'b0;
            in_n = (i + 1 > DEPTH) ? DEPTH : i + 1;
            rd(3'd2, v); chk("R8 in fill events", v, 8'h80 | ev_byte(0, in_n, 1'b1));
        end
        rd(3'd3, v); chk("R6 in full", v, 8'h16);
        chk("R6 in ready", cdc_in_ready, 0);
        for (int i = 0; i < DEPTH + 2; i++) begin
            rd(3'd4, v);
            if (i < DEPTH) chk("R4 in order", v, (i * 13 + 5) & 8'hFF);
        end
        rd(3'd3, v); chk("R7 in empty", v, 8'h15);
        rd(3'd2, v); chk("R11 in half clears", v, 8'h8E);

        // R5 control FIFO gating and order
        wr(3'd1, 8'h00);
        for (int i = 0; i < CDEP + 1; i++) wr(3'd5, 8'(8'h40 + i));
        rd(3'd3, v); chk("R6 ctl full", v, 8'h25);
        rd(3'd2, v); chk("R5 ctl not empty", v, 8'h8A);
        cdc_cmd_pop = 1'b1; @(negedge clk); cdc_cmd_pop = 1'b0;
        chk("R5 avail gated", cdc_cmd_avail, 0);
        rd(3'd3, v); chk("R5 gated pop", v, 8'h25);
        wr(3'd1, 8'h04);
        for (int i = 0; i < CDEP; i++) begin
            cdc_cmd_pop = 1'b1;
            #1 chk("R5 cmd order", cdc_cmd_data, 8'h40 + i);
            @(negedge clk);
            cdc_cmd_pop = 1'b0;
        end
        rd(3'd2, v); chk("R11 ctl empty back", v, 8'h8E);

        // R2 soft reset keeps enables
        wr(3'd1, 8'h8D);
        wr(3'd4, 8'h11); wr(3'd5, 8'h22);
        cdc_in_push = 1'b1; @(negedge clk); cdc_in_push = 1'b0;
        wr(3'd2, 8'h50);
        wr(3'd0, 8'h3C);
        rd(3'd1, v); chk("R2 csr cleared", v, 8'h40);
        rd(3'd3, v); chk("R2 fifos flushed", v, 8'h15);
        rd(3'd2, v); chk("R2 enables kept", v, 8'h5E);
        chk("R2 irq low", irq, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule